// File: doc/BRIEF.md
# Banked Extensible CPU Register File

This block holds the programmer-visible registers of a CPU core. There are four banks. Each bank has a primary set and an alternate set. Each set contains an accumulator, a flag byte, three byte pairs (B:C, D:E, H:L) and two index registers (IX, IY). The pair and index registers are 32 bits wide. Their upper 16 bits form an extension that is reached only by long-word transfers or by a half-swap. The refresh byte R, and the I, SP and PC registers, exist once and are shared by every bank.

A decode stage drives the block. Register codes are interpreted in one of two spaces, chosen by a per-port size bit: the byte space or the word space. The width of a word transfer is set by the global long-mode input, never by the register code. The active bank and the alternate set are held in an internal select register, which is loaded through its own write strobe.

The block has one synchronous write port, which also executes the half-swap command. It has two combinational read ports. Every read result is zero-extended to 32 bits.

Top module: `banked_regfile`

## Requirements
- R1: While rst_ni is low, every register in all banks and both sets, and every shared register, is cleared. The select register returns to bank 0 with the primary set, so sel_bank_o = 0 and sel_alt_o = 0.
- R2: When sel_we_i is high at a clock edge, sel_bank_o and sel_alt_o take sel_bank_i and sel_alt_i. Otherwise they hold. A write or swap in the same cycle as a select load acts on the previously selected bank and set.
- R3: A write into one bank leaves the registers of the other banks unchanged.
- R4: The primary set (sel_alt_o = 0) and the alternate set (sel_alt_o = 1) of a bank are independent storage.
- R5: Byte codes (size bit 0) are A=0, F=1, B=2, C=3, D=4, E=5, H=6, L=7. B, D and H are bits 15:8 of BC, DE and HL, and C, E and L are bits 7:0.
- R6: Word codes (size bit 1) are BC=0, DE=1, HL=2, IX=3, IY=4, SP=5, I=6, PC=7. With long_mode_i low, a word read returns bits 15:0 with bits 31:16 zero, and a word write replaces bits 15:0 and leaves the extension unchanged.
- R7: With long_mode_i high, a word write stores all 32 bits and a word read returns all 32 bits.
- R8: When swap_i is high, the word register at wr_addr_i (word code) has its two 16-bit halves exchanged, whatever the mode. wr_en_i is ignored in that cycle.
- R9: R (byte code 12), I (word code 6, byte code 13 = I bits 7:0), SP and PC are shared. A write made in one bank or set is visible from every other.
- R10: Byte codes IXU=8 and IXL=9 are bits 15:8 and 7:0 of IX. IYU=10 and IYL=11 are the same bits of IY.
- R11: Reads are combinational. A read of a register being written in the same cycle returns the value it held before the edge.
- R12: Byte reads return the byte in bits 7:0 with bits 31:8 zero, and byte writes use only wr_data_i bits 7:0. Byte codes 14 and 15 and word codes 8 to 15 read as zero, and writes or swaps to them change nothing.
- R13: The two read ports are identical. With the same code and size they return the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_we_i | input | 1 | Load the select register |
| sel_bank_i | input | BANK_W | Bank to select |
| sel_alt_i | input | 1 | 1 selects the alternate set |
| long_mode_i | input | 1 | 1: word transfers are 32 bits, 0: 16 bits |
| wr_en_i | input | 1 | Write strobe |
| swap_i | input | 1 | Exchange halves of the word register at wr_addr_i |
| wr_word_i | input | 1 | Write size: 0 byte space, 1 word space |
| wr_addr_i | input | 4 | Write/swap register code |
| wr_data_i | input | 32 | Write data |
| rd_a_addr_i | input | 4 | Read port A register code |
| rd_a_word_i | input | 1 | Read port A size |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register code |
| rd_b_word_i | input | 1 | Read port B size |
| rd_b_data_o | output | 32 | Read port B data |
| sel_bank_o | output | BANK_W | Current bank |
| sel_alt_o | output | 1 | Current set |

## Verification
The checker enforces the following on every cycle: the select register load and hold, zero-extension of byte reads and 16-bit word reads, agreement of the two read ports, the half exchange of a swap, and the 32-bit write-then-read path.

Several behaviours show up only in the bench's scenarios, compared cycle by cycle against a behavioural model:
- the preservation of an extension across a 16-bit write
- byte aliasing into pairs and index halves
- bank and set isolation
- the visibility of shared registers across banks
- the old-value return during a same-cycle write
- the silence of unused codes

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int DATA_W    = 32;
  localparam int HALF_W    = DATA_W / 2;
  localparam int WORD_REGS = 5;  // BC, DE, HL, IX, IY

  typedef enum logic [3:0] {
    BY_A = 4'd0, BY_F = 4'd1, BY_B = 4'd2, BY_C = 4'd3,
    BY_D = 4'd4, BY_E = 4'd5, BY_H = 4'd6, BY_L = 4'd7,
    BY_IXU = 4'd8, BY_IXL = 4'd9, BY_IYU = 4'd10, BY_IYL = 4'd11,
    BY_R = 4'd12, BY_I = 4'd13, BY_NA0 = 4'd14, BY_NA1 = 4'd15
  } byte_code_e;

  typedef enum logic [2:0] {
    WD_BC = 3'd0, WD_DE = 3'd1, WD_HL = 3'd2, WD_IX = 3'd3,
    WD_IY = 3'd4, WD_SP = 3'd5, WD_I = 3'd6, WD_PC = 3'd7
  } word_code_e;

  // registers visible through the current bank/set selection
  typedef struct packed {
    logic [7:0]                        a;
    logic [7:0]                        f;
    logic [WORD_REGS-1:0][DATA_W-1:0]  w;
    logic [7:0]                        r;
    logic [DATA_W-1:0]                 iv;
    logic [DATA_W-1:0]                 sp;
    logic [DATA_W-1:0]                 pc;
  } view_t;
endpackage

// File: rtl/rf_sel_reg.sv
module rf_sel_reg #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              alt_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              alt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= '0;
      alt_o  <= 1'b0;
    end else if (we_i) begin
      bank_o <= bank_i;
      alt_o  <= alt_i;
    end
  end
endmodule

// File: rtl/rf_store.sv
module rf_store
  import regfile_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              alt_i,
  input  logic              long_i,
  input  logic              wr_en_i,
  input  logic              swap_i,
  input  logic              wr_word_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output view_t             view_o
);
  logic [7:0]        acc_q [NUM_BANKS][2];
  logic [7:0]        flg_q [NUM_BANKS][2];
  logic [DATA_W-1:0] wrd_q [NUM_BANKS][2][WORD_REGS];
  logic [7:0]        r_q;
  logic [DATA_W-1:0] i_q, sp_q, pc_q;

  view_t cur, nxt;
  logic  upd;

  always_comb begin
    cur.a  = acc_q[bank_i][alt_i];
    cur.f  = flg_q[bank_i][alt_i];
    for (int k = 0; k < WORD_REGS; k++) cur.w[k] = wrd_q[bank_i][alt_i][k];
    cur.r  = r_q;
    cur.iv = i_q;
    cur.sp = sp_q;
    cur.pc = pc_q;
  end

  assign view_o = cur;
  assign upd    = swap_i | wr_en_i;

  function automatic logic [DATA_W-1:0] halves_x(input logic [DATA_W-1:0] v);
    return {v[HALF_W-1:0], v[DATA_W-1:HALF_W]};
  endfunction

  // word write: extension kept unless long mode
  function automatic logic [DATA_W-1:0] word_merge(input logic [DATA_W-1:0] old,
                                                   input logic [DATA_W-1:0] d,
                                                   input logic lng);
    return lng ? d : {old[DATA_W-1:HALF_W], d[HALF_W-1:0]};
  endfunction

  always_comb begin
    nxt = cur;
    if (swap_i) begin
      if (!wr_addr_i[3]) begin
        unique case (word_code_e'(wr_addr_i[2:0]))
          WD_BC: nxt.w[0] = halves_x(cur.w[0]);
          WD_DE: nxt.w[1] = halves_x(cur.w[1]);
          WD_HL: nxt.w[2] = halves_x(cur.w[2]);
          WD_IX: nxt.w[3] = halves_x(cur.w[3]);
          WD_IY: nxt.w[4] = halves_x(cur.w[4]);
          WD_SP: nxt.sp   = halves_x(cur.sp);
          WD_I:  nxt.iv   = halves_x(cur.iv);
          WD_PC: nxt.pc   = halves_x(cur.pc);
        endcase
      end
    end else if (wr_en_i) begin
      if (wr_word_i) begin
        if (!wr_addr_i[3]) begin
          unique case (word_code_e'(wr_addr_i[2:0]))
            WD_BC: nxt.w[0] = word_merge(cur.w[0], wr_data_i, long_i);
            WD_DE: nxt.w[1] = word_merge(cur.w[1], wr_data_i, long_i);
            WD_HL: nxt.w[2] = word_merge(cur.w[2], wr_data_i, long_i);
            WD_IX: nxt.w[3] = word_merge(cur.w[3], wr_data_i, long_i);
            WD_IY: nxt.w[4] = word_merge(cur.w[4], wr_data_i, long_i);
            WD_SP: nxt.sp   = word_merge(cur.sp, wr_data_i, long_i);
            WD_I:  nxt.iv   = word_merge(cur.iv, wr_data_i, long_i);
            WD_PC: nxt.pc   = word_merge(cur.pc, wr_data_i, long_i);
          endcase
        end
      end else begin
        unique case (byte_code_e'(wr_addr_i))
          BY_A:   nxt.a         = wr_data_i[7:0];
          BY_F:   nxt.f         = wr_data_i[7:0];
          BY_B:   nxt.w[0][15:8] = wr_data_i[7:0];
          BY_C:   nxt.w[0][7:0]  = wr_data_i[7:0];
          BY_D:   nxt.w[1][15:8] = wr_data_i[7:0];
          BY_E:   nxt.w[1][7:0]  = wr_data_i[7:0];
          BY_H:   nxt.w[2][15:8] = wr_data_i[7:0];
          BY_L:   nxt.w[2][7:0]  = wr_data_i[7:0];
          BY_IXU: nxt.w[3][15:8] = wr_data_i[7:0];
          BY_IXL: nxt.w[3][7:0]  = wr_data_i[7:0];
          BY_IYU: nxt.w[4][15:8] = wr_data_i[7:0];
          BY_IYL: nxt.w[4][7:0]  = wr_data_i[7:0];
          BY_R:   nxt.r         = wr_data_i[7:0];
          BY_I:   nxt.iv[7:0]   = wr_data_i[7:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int s = 0; s < 2; s++) begin
          acc_q[b][s] <= '0;
          flg_q[b][s] <= '0;
          for (int k = 0; k < WORD_REGS; k++) wrd_q[b][s][k] <= '0;
        end
      end
      r_q  <= '0;
      i_q  <= '0;
      sp_q <= '0;
      pc_q <= '0;
    end else if (upd) begin
      acc_q[bank_i][alt_i] <= nxt.a;
      flg_q[bank_i][alt_i] <= nxt.f;
      for (int k = 0; k < WORD_REGS; k++) wrd_q[bank_i][alt_i][k] <= nxt.w[k];
      r_q  <= nxt.r;
      i_q  <= nxt.iv;
      sp_q <= nxt.sp;
      pc_q <= nxt.pc;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import regfile_pkg::*;
(
  input  view_t             view_i,
  input  logic              long_i,
  input  logic              word_i,
  input  logic [3:0]        addr_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] wv;
  logic [7:0]        bv;
  logic              wvalid, bvalid;

  always_comb begin
    wv     = '0;
    wvalid = ~addr_i[3];
    unique case (word_code_e'(addr_i[2:0]))
      WD_BC: wv = view_i.w[0];
      WD_DE: wv = view_i.w[1];
      WD_HL: wv = view_i.w[2];
      WD_IX: wv = view_i.w[3];
      WD_IY: wv = view_i.w[4];
      WD_SP: wv = view_i.sp;
      WD_I:  wv = view_i.iv;
      WD_PC: wv = view_i.pc;
    endcase
  end

  always_comb begin
    bv     = '0;
    bvalid = 1'b1;
    unique case (byte_code_e'(addr_i))
      BY_A:   bv = view_i.a;
      BY_F:   bv = view_i.f;
      BY_B:   bv = view_i.w[0][15:8];
      BY_C:   bv = view_i.w[0][7:0];
      BY_D:   bv = view_i.w[1][15:8];
      BY_E:   bv = view_i.w[1][7:0];
      BY_H:   bv = view_i.w[2][15:8];
      BY_L:   bv = view_i.w[2][7:0];
      BY_IXU: bv = view_i.w[3][15:8];
      BY_IXL: bv = view_i.w[3][7:0];
      BY_IYU: bv = view_i.w[4][15:8];
      BY_IYL: bv = view_i.w[4][7:0];
      BY_R:   bv = view_i.r;
      BY_I:   bv = view_i.iv[7:0];
      default: bvalid = 1'b0;
    endcase
  end

  always_comb begin
    data_o = '0;
    if (word_i) begin
      if (wvalid) data_o = long_i ? wv : {{HALF_W{1'b0}}, wv[HALF_W-1:0]};
    end else if (bvalid) begin
      data_o = {{(DATA_W-8){1'b0}}, bv};
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regfile_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_we_i,
  input  logic [BANK_W-1:0] sel_bank_i,
  input  logic              sel_alt_i,
  input  logic              long_mode_i,
  input  logic              wr_en_i,
  input  logic              swap_i,
  input  logic              wr_word_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [3:0]        rd_a_addr_i,
  input  logic              rd_a_word_i,
  output logic [31:0]       rd_a_data_o,
  input  logic [3:0]        rd_b_addr_i,
  input  logic              rd_b_word_i,
  output logic [31:0]       rd_b_data_o,
  output logic [BANK_W-1:0] sel_bank_o,
  output logic              sel_alt_o
);
  localparam int NUM_RD = 2;

  view_t             view;
  logic [3:0]        rd_addr [NUM_RD];
  logic              rd_word [NUM_RD];
  logic [DATA_W-1:0] rd_data [NUM_RD];

  rf_sel_reg #(.NUM_BANKS(NUM_BANKS)) sel_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sel_we_i),
    .bank_i (sel_bank_i),
    .alt_i  (sel_alt_i),
    .bank_o (sel_bank_o),
    .alt_o  (sel_alt_o)
  );

  rf_store #(.NUM_BANKS(NUM_BANKS)) store_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bank_i    (sel_bank_o),
    .alt_i     (sel_alt_o),
    .long_i    (long_mode_i),
    .wr_en_i   (wr_en_i),
    .swap_i    (swap_i),
    .wr_word_i (wr_word_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .view_o    (view)
  );

  assign rd_addr[0]  = rd_a_addr_i;
  assign rd_word[0]  = rd_a_word_i;
  assign rd_addr[1]  = rd_b_addr_i;
  assign rd_word[1]  = rd_b_word_i;
  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port port_i (
      .view_i (view),
      .long_i (long_mode_i),
      .word_i (rd_word[p]),
      .addr_i (rd_addr[p]),
      .data_o (rd_data[p])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_we_i,
  input logic [BANK_W-1:0] sel_bank_i,
  input logic              sel_alt_i,
  input logic              long_mode_i,
  input logic              wr_en_i,
  input logic              swap_i,
  input logic              wr_word_i,
  input logic [3:0]        wr_addr_i,
  input logic [31:0]       wr_data_i,
  input logic [3:0]        rd_a_addr_i,
  input logic              rd_a_word_i,
  input logic [31:0]       rd_a_data_o,
  input logic [3:0]        rd_b_addr_i,
  input logic              rd_b_word_i,
  input logic [31:0]       rd_b_data_o,
  input logic [BANK_W-1:0] sel_bank_o,
  input logic              sel_alt_o
);
  // R2
  sel_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> (sel_bank_o == $past(sel_bank_i) && sel_alt_o == $past(sel_alt_i)));

  // R2
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> ($stable(sel_bank_o) && $stable(sel_alt_o)));

  // R6
  word_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_word_i && !long_mode_i) |-> rd_a_data_o[31:16] == 16'h0);

  // R12
  byte_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_b_word_i |-> rd_b_data_o[31:8] == 24'h0);

  // R13
  port_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == rd_b_addr_i && rd_a_word_i == rd_b_word_i) |-> rd_a_data_o == rd_b_data_o);

  // R8
  swap_halves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && !wr_addr_i[3] && !sel_we_i && rd_a_word_i && long_mode_i && rd_a_addr_i == wr_addr_i)
    |=> (!(rd_a_word_i && long_mode_i && rd_a_addr_i == $past(wr_addr_i))
         || rd_a_data_o == {$past(rd_a_data_o[15:0]), $past(rd_a_data_o[31:16])}));

  // R7
  long_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !swap_i && wr_word_i && long_mode_i && !wr_addr_i[3] && !sel_we_i)
    |=> (!(rd_b_word_i && long_mode_i && rd_b_addr_i == $past(wr_addr_i))
         || rd_b_data_o == $past(wr_data_i)));
endmodule

bind banked_regfile rf_checker #(.NUM_BANKS(NUM_BANKS)) chk_i (.*);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
  localparam int NB = 4;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_we = 1'b0;
  logic [BW-1:0] sel_bank = '0;
  logic          sel_alt = 1'b0;
  logic          long_mode = 1'b1;
  logic          wr_en = 1'b0, swap = 1'b0, wr_word = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    ra = '0, rb = '0;
  logic          raw = 1'b0, rbw = 1'b0;
  logic [31:0]   rda, rdb;
  logic [BW-1:0] bank_o;
  logic          alt_o;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  banked_regfile #(.NUM_BANKS(NB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_we_i(sel_we), .sel_bank_i(sel_bank),
    .sel_alt_i(sel_alt), .long_mode_i(long_mode), .wr_en_i(wr_en), .swap_i(swap),
    .wr_word_i(wr_word), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_a_addr_i(ra), .rd_a_word_i(raw), .rd_a_data_o(rda),
    .rd_b_addr_i(rb), .rd_b_word_i(rbw), .rd_b_data_o(rdb),
    .sel_bank_o(bank_o), .sel_alt_o(alt_o)
  );

  // model: slots 0 A,1 F,2 BC,3 DE,4 HL,5 IX,6 IY (banked); 7 R,8 I,9 SP,10 PC (shared, kept in [0][0])
  logic [31:0] st [NB][2][11];
  int          m_bank = 0, m_alt = 0;

  function automatic int byte_loc(input int code);
    if (code == 0 || code == 1) return code * 2;
    if (code >= 2 && code <= 11) return (2 + (code - 2) / 2) * 2 + (((code - 2) % 2 == 0) ? 1 : 0);
    if (code == 12) return 14;
    if (code == 13) return 16;
    return -1;
  endfunction

  function automatic int word_loc(input int code);
    if (code <= 4) return 2 + code;
    if (code == 5) return 9;
    if (code == 6) return 8;
    if (code == 7) return 10;
    return -1;
  endfunction

  function automatic logic [31:0] mget(input int idx);
    return (idx >= 7) ? st[0][0][idx] : st[m_bank][m_alt][idx];
  endfunction

  function automatic logic [31:0] model_read(input int code, input bit wrd, input bit lng);
    int l;
    logic [31:0] v;
    if (wrd) begin
      l = word_loc(code);
      if (l < 0) return 0;
      v = mget(l);
      return lng ? v : (v & 32'h0000ffff);
    end
    l = byte_loc(code);
    if (l < 0) return 0;
    v = mget(l / 2);
    return (l % 2 == 1) ? ((v >> 8) & 32'hff) : (v & 32'hff);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model_upd
    int l, idx, b, a;
    logic [31:0] v;
    if (!rst_n) begin
      foreach (st[i, j, k]) st[i][j][k] = '0;
      m_bank = 0;
      m_alt  = 0;
    end else begin
      idx = -1;
      v   = '0;
      if (swap) begin
        idx = word_loc(int'(wr_addr));
        if (idx >= 0) begin
          v = mget(idx);
          v = {v[15:0], v[31:16]};
        end
      end else if (wr_en) begin
        if (wr_word) begin
          idx = word_loc(int'(wr_addr));
          if (idx >= 0) begin
            v = mget(idx);
            v = long_mode ? wr_data : {v[31:16], wr_data[15:0]};
          end
        end else begin
          l = byte_loc(int'(wr_addr));
          if (l >= 0) begin
            idx = l / 2;
            v = mget(idx);
            if (l % 2 == 1) v[15:8] = wr_data[7:0];
            else v[7:0] = wr_data[7:0];
          end
        end
      end
      if (idx >= 0) begin
        b = (idx >= 7) ? 0 : m_bank;
        a = (idx >= 7) ? 0 : m_alt;
        st[b][a][idx] = v;
      end
      if (sel_we) begin
        m_bank = int'(sel_bank);
        m_alt  = int'(sel_alt);
      end
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // drive done before call; compare pre-edge, then let the edge happen
  task automatic cyc();
    #1;
    check("port A", rda, model_read(int'(ra), raw, long_mode));
    check("port B", rdb, model_read(int'(rb), rbw, long_mode));
    check("bank", 32'(bank_o), 32'(m_bank));
    check("alt", 32'(alt_o), 32'(m_alt));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; swap = 0; sel_we = 0;
  endtask

  task automatic wr(input bit w, input int code, input logic [31:0] d);
    idle();
    wr_en = 1; wr_word = w; wr_addr = 4'(code); wr_data = d;
    cyc();
    idle();
  endtask

  task automatic rd(input int a, input bit aw, input int b, input bit bw);
    ra = 4'(a); raw = aw; rb = 4'(b); rbw = bw;
    cyc();
  endtask

  task automatic sel(input int b, input bit a);
    idle();
    sel_we = 1; sel_bank = BW'(b); sel_alt = a;
    cyc();
    idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    rd(0, 1, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 16; c++) rd(c, 1, c, 0);

    cur_req = "R7";
    long_mode = 1;
    wr(1, 0, 32'h11223344);
    rd(0, 1, 7, 1);

    cur_req = "R5";
    rd(2, 0, 3, 0);
    wr(0, 4, 32'hffffffab);
    wr(0, 5, 32'h000000cd);
    rd(1, 1, 4, 0);
    wr(0, 6, 32'h5e);
    wr(0, 7, 32'h6f);
    rd(2, 1, 6, 0);

    cur_req = "R6";
    wr(1, 2, 32'hdeadbeef);
    long_mode = 0;
    wr(1, 2, 32'hcafe1234);
    rd(2, 1, 6, 0);
    long_mode = 1;
    rd(2, 1, 7, 0);

    cur_req = "R10";
    wr(0, 8, 32'h5a);
    wr(0, 9, 32'ha5);
    wr(0, 10, 32'h3c);
    wr(0, 11, 32'hc3);
    rd(3, 1, 4, 1);
    rd(8, 0, 11, 0);

    cur_req = "R12";
    wr(0, 0, 32'hffffff81);
    wr(0, 1, 32'h7e);
    wr(0, 14, 32'hffffffff);
    wr(1, 9, 32'hffffffff);
    rd(0, 0, 1, 0);
    rd(14, 0, 9, 1);
    rd(0, 1, 15, 0);

    cur_req = "R8";
    idle(); swap = 1; wr_addr = 4'd2; ra = 4'd2; raw = 1;
    cyc();
    idle();
    rd(2, 1, 2, 1);
    long_mode = 0;
    idle(); swap = 1; wr_en = 1; wr_word = 1; wr_addr = 4'd0; wr_data = 32'h99999999;
    cyc();
    idle();
    long_mode = 1;
    rd(0, 1, 12, 1);

    cur_req = "R2";
    idle(); sel_we = 1; sel_bank = 2'd2; sel_alt = 0;
    wr_en = 1; wr_word = 1; wr_addr = 4'd1; wr_data = 32'h0badf00d;
    cyc();
    idle();
    rd(1, 1, 1, 1);
    sel(0, 0);
    rd(1, 1, 0, 1);

    cur_req = "R3";
    sel(2, 0);
    wr(1, 0, 32'h22222222);
    sel(1, 0);
    rd(0, 1, 1, 1);
    sel(0, 0);
    rd(0, 1, 2, 1);

    cur_req = "R4";
    sel(0, 1);
    rd(0, 1, 0, 0);
    wr(1, 0, 32'h44444444);
    wr(0, 0, 32'h12);
    sel(0, 0);
    rd(0, 1, 0, 0);

    cur_req = "R9";
    sel(3, 1);
    wr(1, 5, 32'h76543210);
    wr(0, 12, 32'h41);
    wr(1, 6, 32'h0000ab00);
    wr(0, 13, 32'h77);
    wr(1, 7, 32'h00c0ffee);
    sel(1, 0);
    rd(5, 1, 12, 0);
    rd(6, 1, 7, 1);
    rd(13, 0, 6, 1);

    cur_req = "R11";
    ra = 4'd3; raw = 1; rb = 4'd3; rbw = 1;
    wr(1, 3, 32'h13572468);
    rd(3, 1, 3, 1);

    cur_req = "R13";
    for (int c = 0; c < 16; c++) rd(c, c[0], c, c[0]);

    cur_req = "R3 R4 R8 R12 mixed";
    for (int n = 0; n < 4000; n++) begin
      idle();
      long_mode = 1'($urandom);
      wr_en     = 1'($urandom);
      swap      = (($urandom % 8) == 0);
      wr_word   = 1'($urandom);
      wr_addr   = 4'($urandom);
      wr_data   = $urandom;
      sel_we    = (($urandom % 6) == 0);
      sel_bank  = BW'($urandom);
      sel_alt   = 1'($urandom);
      ra = 4'($urandom); raw = 1'($urandom);
      rb = 4'($urandom); rbw = 1'($urandom);
      cyc();
    end
    idle();

    cur_req = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    rd(0, 1, 1, 1);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2, 1, 5, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule